// File: doc/BRIEF.md
# Byte-Serial Mesh Packet Transmitter with Read/Write Backpressure

This block takes one 104-bit mesh transaction at a time from a valid/ready source and sends it over a link one byte per clock, with a FRAME line held high for every byte of the packet. The first byte packs the control nibble, the size code and the read/write flags. It is followed by the destination address, the data word and, when needed, the source address, each most significant byte first. A write of 8, 16 or 32 bits takes nine bytes. A read request, or a 64-bit write whose upper word travels in the source-address slot, takes thirteen.

The far receiver pushes back through two wait lines, one for reads and one for writes. Their phase relative to the local clock is unknown, so each passes through a two-flop synchronizer first. A synchronized wait only stops a new packet of its own kind from being accepted. A packet already on the wire always runs to its last byte. FRAME returns low for at least one cycle after every packet, and the data bus reads zero whenever FRAME is low.

Top module: `lnk_pkt_tx`

## Requirements
- R1: After reset, txFrame is 0, txData is 0 and inReady is 1 while both wait inputs are low.
- R2: A packet accepted on a clock edge (inValid and inReady both high) raises txFrame in the next cycle. In that cycle txData carries byte0 = {ctrlMode[3:0], dataMode[1:0], write, access} (bit 7 down to bit 0).
- R3: Bytes 1 to 4 carry dstAddr and bytes 5 to 8 carry data, each word most significant byte first, one byte per cycle.
- R4: txFrame stays high for exactly 13 cycles for a read (write = 0) or a 64-bit write (dataMode = 2'b11), and for exactly 9 cycles otherwise (dataMode 2'b00, 2'b01, 2'b10 as 8, 16, 32 bits).
- R5: In a 13-byte packet, bytes 9 to 12 carry srcAddr, most significant byte first.
- R6: inReady is low whenever txFrame is high, so txFrame is low for at least one cycle between packets.
- R7: A change on a wait input changes inReady only after two rising clock edges, and not after one.
- R8: A synchronized read-wait holds inReady low for read packets (write = 0) and leaves write packets unaffected.
- R9: A synchronized write-wait holds inReady low for write packets (write = 1) and leaves read packets unaffected.
- R10: A wait that rises while a packet is being sent neither shortens nor stalls that packet.
- R11: txData is 0 in every cycle in which txFrame is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one byte per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Source offers a packet |
| inReady | output | 1 | Block accepts the offered packet on this edge |
| inAccess | input | 1 | Packet valid flag carried in byte0 |
| inWrite | input | 1 | 1 = write, 0 = read request |
| inDataMode | input | 2 | Size code: 00 8b, 01 16b, 10 32b, 11 64b |
| inCtrlMode | input | 4 | Control nibble carried in byte0 |
| inDstAddr | input | 32 | Destination address |
| inData | input | 32 | Write data or lower data word |
| inSrcAddr | input | 32 | Return address or upper data word |
| rdWaitAsync | input | 1 | Read backpressure from far receiver, any phase |
| wrWaitAsync | input | 1 | Write backpressure from far receiver, any phase |
| txData | output | 8 | Link byte |
| txFrame | output | 1 | High for every byte of a packet |

## Verification
Writes of each of the three short sizes are sent to confirm nine-byte framing. A 64-bit write and a read are sent to separate the two thirteen-byte cases, one carrying upper data and one carrying a return address. Each wait line is raised while reads and writes are offered in turn, which shows that each line gates only its own kind. Sampling inReady one edge and then two edges after a wait changes shows the synchronizer depth. A packet with both waits raised part-way through shows that a packet in flight is never cut short, and two packets sent back to back show the idle gap between them.

// File: rtl/lnk_pkt_tx_pkg.sv
package lnk_pkt_tx_pkg;

  localparam int LNK_BYTE_W    = 8;
  localparam int LNK_ADDR_W    = 32;
  localparam int LNK_DATA_W    = 32;
  localparam int LNK_CTRL_W    = 4;
  localparam int LNK_MODE_W    = 2;
  localparam int LNK_ADDR_BYTES = LNK_ADDR_W / LNK_BYTE_W;
  localparam int LNK_DATA_BYTES = LNK_DATA_W / LNK_BYTE_W;
  // header byte + destination + data
  localparam int LNK_SHORT_BYTES = 1 + LNK_ADDR_BYTES + LNK_DATA_BYTES;
  // plus source address / upper data
  localparam int LNK_LONG_BYTES  = LNK_SHORT_BYTES + LNK_ADDR_BYTES;
  localparam int LNK_PKT_W       = LNK_LONG_BYTES * LNK_BYTE_W;
  localparam int LNK_CNT_W       = $clog2(LNK_LONG_BYTES);

  typedef enum logic [LNK_MODE_W-1:0] {
    SIZE_8  = 2'b00,
    SIZE_16 = 2'b01,
    SIZE_32 = 2'b10,
    SIZE_64 = 2'b11
  } txSize_e;

  // Field order equals wire order: the top byte goes out first.
  typedef struct packed {
    logic [LNK_CTRL_W-1:0] ctrlMode;
    logic [LNK_MODE_W-1:0] dataMode;
    logic                  write;
    logic                  access;
    logic [LNK_ADDR_W-1:0] dstAddr;
    logic [LNK_DATA_W-1:0] data;
    logic [LNK_ADDR_W-1:0] srcAddr;
  } meshPkt_t;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic load;
    logic shift;
    logic clear;
  } txStrobe_t;

  function automatic logic isLongPkt(input logic write, input logic [LNK_MODE_W-1:0] dataMode);
    return !write || (dataMode == SIZE_64);
  endfunction

endpackage

// File: rtl/lnk_pkt_tx_sync.sv
module lnk_pkt_tx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/lnk_pkt_tx_ctrl.sv
module lnk_pkt_tx_ctrl
  import lnk_pkt_tx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic                  inWrite,
  input  logic [LNK_MODE_W-1:0] inDataMode,
  input  logic                  rdWaitSync,
  input  logic                  wrWaitSync,
  output logic                  inReady,
  output logic                  txFrame,
  output txStrobe_t             strobe
);

  typedef enum logic {ST_IDLE, ST_SEND} txState_e;

  localparam logic [LNK_CNT_W-1:0] SHORT_LAST = LNK_CNT_W'(LNK_SHORT_BYTES - 1);
  localparam logic [LNK_CNT_W-1:0] LONG_LAST  = LNK_CNT_W'(LNK_LONG_BYTES - 1);

  txState_e             stateQ;
  logic [LNK_CNT_W-1:0] byteCntQ;
  logic [LNK_CNT_W-1:0] lastIdxQ;
  logic                 blocked;
  logic                 accept;
  logic                 atLast;

  always_comb begin
    blocked      = inWrite ? wrWaitSync : rdWaitSync;
    inReady      = (stateQ == ST_IDLE) && !blocked;
    accept       = inValid && inReady;
    atLast       = (byteCntQ == lastIdxQ);
    txFrame      = (stateQ == ST_SEND);
    strobe.load  = accept;
    strobe.shift = (stateQ == ST_SEND) && !atLast;
    strobe.clear = (stateQ == ST_SEND) && atLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      byteCntQ <= '0;
      lastIdxQ <= SHORT_LAST;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (accept) begin
            stateQ   <= ST_SEND;
            byteCntQ <= '0;
            lastIdxQ <= isLongPkt(inWrite, inDataMode) ? LONG_LAST : SHORT_LAST;
          end
        end
        ST_SEND: begin
          if (atLast) stateQ <= ST_IDLE;
          else        byteCntQ <= byteCntQ + 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lnk_pkt_tx_dpath.sv
module lnk_pkt_tx_dpath
  import lnk_pkt_tx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  txStrobe_t             strobe,
  input  meshPkt_t              pktIn,
  output logic [LNK_BYTE_W-1:0] txData
);

  logic [LNK_PKT_W-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (strobe.load) begin
      shiftQ <= pktIn;
    end else if (strobe.clear) begin
      shiftQ <= '0;
    end else if (strobe.shift) begin
      shiftQ <= {shiftQ[LNK_PKT_W-LNK_BYTE_W-1:0], {LNK_BYTE_W{1'b0}}};
    end
  end

  assign txData = shiftQ[LNK_PKT_W-1 -: LNK_BYTE_W];

endmodule

// File: rtl/lnk_pkt_tx.sv
module lnk_pkt_tx
  import lnk_pkt_tx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic                  inAccess,
  input  logic                  inWrite,
  input  logic [LNK_MODE_W-1:0] inDataMode,
  input  logic [LNK_CTRL_W-1:0] inCtrlMode,
  input  logic [LNK_ADDR_W-1:0] inDstAddr,
  input  logic [LNK_DATA_W-1:0] inData,
  input  logic [LNK_ADDR_W-1:0] inSrcAddr,
  input  logic                  rdWaitAsync,
  input  logic                  wrWaitAsync,
  output logic [LNK_BYTE_W-1:0] txData,
  output logic                  txFrame
);

  logic [1:0] waitSync;
  txStrobe_t  strobe;
  meshPkt_t   pktIn;

  always_comb begin
    pktIn.ctrlMode = inCtrlMode;
    pktIn.dataMode = inDataMode;
    pktIn.write    = inWrite;
    pktIn.access   = inAccess;
    pktIn.dstAddr  = inDstAddr;
    pktIn.data     = inData;
    pktIn.srcAddr  = inSrcAddr;
  end

  lnk_pkt_tx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({wrWaitAsync, rdWaitAsync}),
    .syncOut (waitSync)
  );

  lnk_pkt_tx_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inWrite    (inWrite),
    .inDataMode (inDataMode),
    .rdWaitSync (waitSync[0]),
    .wrWaitSync (waitSync[1]),
    .inReady    (inReady),
    .txFrame    (txFrame),
    .strobe     (strobe)
  );

  lnk_pkt_tx_dpath dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .pktIn  (pktIn),
    .txData (txData)
  );

endmodule

// File: rtl/lnk_pkt_tx_chk.sv
module lnk_pkt_tx_chk
  import lnk_pkt_tx_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  inValid,
  input logic                  inReady,
  input logic                  inWrite,
  input logic                  rdWaitAsync,
  input logic                  wrWaitAsync,
  input logic [LNK_BYTE_W-1:0] txData,
  input logic                  txFrame
);

  logic [1:0] sinceRst;
  logic [4:0] frameLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
      frameLen <= '0;
    end else begin
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 1'b1;
      frameLen <= txFrame ? frameLen + 1'b1 : '0;
    end
  end

  assert_ready_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !txFrame);

  assert_accept_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> txFrame);

  assert_frame_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txFrame) |-> $past(inValid && inReady));

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    !txFrame |-> (txData == '0));

  assert_frame_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txFrame) |-> (frameLen == 5'(LNK_SHORT_BYTES) || frameLen == 5'(LNK_LONG_BYTES)));

  assert_rd_block_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && $past(rdWaitAsync, 2) && !inWrite) |-> !inReady);

  assert_wr_block_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && $past(wrWaitAsync, 2) && inWrite) |-> !inReady);

  assert_wait_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && !$past(rdWaitAsync, 2) && !$past(wrWaitAsync, 2) && !txFrame)
      |-> inReady);

endmodule

bind lnk_pkt_tx lnk_pkt_tx_chk chk_i (.*);

// File: tb/lnk_pkt_tx_tb_top.sv
module lnk_pkt_tx_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        inAccess = 1'b1;
  logic        inWrite = 1'b0;
  logic [1:0]  inDataMode = 2'b00;
  logic [3:0]  inCtrlMode = 4'h0;
  logic [31:0] inDstAddr = '0;
  logic [31:0] inData = '0;
  logic [31:0] inSrcAddr = '0;
  logic        rdWaitAsync = 1'b0;
  logic        wrWaitAsync = 1'b0;
  logic [7:0]  txData;
  logic        txFrame;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lnk_pkt_tx dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inAccess(inAccess), .inWrite(inWrite), .inDataMode(inDataMode),
    .inCtrlMode(inCtrlMode), .inDstAddr(inDstAddr), .inData(inData),
    .inSrcAddr(inSrcAddr), .rdWaitAsync(rdWaitAsync), .wrWaitAsync(wrWaitAsync),
    .txData(txData), .txFrame(txFrame)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Sends one packet and checks every byte, the length, the gap and ready.
  task automatic send_pkt(input logic wr, input logic [1:0] dm, input logic [3:0] cm,
                          input logic [31:0] dst, input logic [31:0] dat,
                          input logic [31:0] src, input int raiseAt, input string tag);
    logic [103:0] exp;
    int expLen;
    int n;
    int w;
    int badIdx;
    logic [7:0] badGot;
    bit readyLeak;
    exp = {cm, dm, wr, 1'b1, dst, dat, src};
    expLen = (!wr || dm == 2'b11) ? 13 : 9;
    @(negedge clk);
    inValid = 1'b1; inAccess = 1'b1; inWrite = wr; inDataMode = dm;
    inCtrlMode = cm; inDstAddr = dst; inData = dat; inSrcAddr = src;
    #1;
    w = 0;
    while (!inReady && w < 50) begin
      @(negedge clk); #1; w++;
    end
    chk(inReady, {tag, " R7 ready before send"}, inReady, 1);
    @(negedge clk);
    inValid = 1'b0;
    n = 0; badIdx = -1; badGot = 8'h00; readyLeak = 1'b0;
    while (txFrame && n < 16) begin
      if (badIdx < 0 && txData !== exp[103 - 8*n -: 8]) begin
        badIdx = n; badGot = txData;
      end
      if (inReady) readyLeak = 1'b1;
      if (n == raiseAt) begin rdWaitAsync = 1'b1; wrWaitAsync = 1'b1; end
      n++;
      @(negedge clk);
    end
    chk(n == expLen, {tag, " R4 frame length"}, n, expLen);
    if (badIdx < 0)
      chk(1'b1, {tag, " R2 R3 R5 bytes"}, 0, 0);
    else
      chk(1'b0, $sformatf("%s R2 R3 R5 byte%0d", tag, badIdx), badGot, exp[103 - 8*badIdx -: 8]);
    chk(!readyLeak, {tag, " R6 ready low during frame"}, readyLeak, 0);
    chk(!txFrame && txData == 8'h00, {tag, " R6 R11 idle gap"}, {txFrame, txData}, 0);
  endtask

  task automatic t_reset;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(txFrame == 1'b0 && txData == 8'h00, "R1 outputs in reset", {txFrame, txData}, 0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(txFrame == 1'b0 && txData == 8'h00, "R1 outputs after reset", {txFrame, txData}, 0);
    chk(inReady == 1'b1, "R1 ready after reset", inReady, 1);
  endtask

  task automatic t_short_writes;
    send_pkt(1'b1, 2'b00, 4'h5, 32'h1122_3344, 32'h5566_7788, 32'hDEAD_BEEF, -1, "w8");
    send_pkt(1'b1, 2'b01, 4'hA, 32'hA0B0_C0D0, 32'h0F1E_2D3C, 32'h0, -1, "w16");
    send_pkt(1'b1, 2'b10, 4'h3, 32'hFFEE_DDCC, 32'h8001_0080, 32'h1234_5678, -1, "w32");
  endtask

  task automatic t_long_packets;
    send_pkt(1'b1, 2'b11, 4'hC, 32'h0101_0202, 32'h0303_0404, 32'hCAFE_F00D, -1, "w64");
    send_pkt(1'b0, 2'b10, 4'h9, 32'h8765_4321, 32'h0, 32'h00AB_CDEF, -1, "rd");
  endtask

  task automatic t_back_to_back;
    send_pkt(1'b1, 2'b10, 4'h1, 32'h1, 32'h2, 32'h3, -1, "b2b0");
    send_pkt(1'b0, 2'b00, 4'h2, 32'h4, 32'h5, 32'h6, -1, "b2b1");
  endtask

  // Raises one wait, checks latency, that only its own kind is held, then release.
  task automatic t_wait_gate(input bit onRead, input string tag);
    @(negedge clk);
    inValid = 1'b0; inWrite = onRead ? 1'b0 : 1'b1;
    if (onRead) rdWaitAsync = 1'b1; else wrWaitAsync = 1'b1;
    @(negedge clk); #1;
    chk(inReady == 1'b1, {tag, " R7 one edge not enough"}, inReady, 1);
    @(negedge clk); #1;
    chk(inReady == 1'b0, {tag, onRead ? " R8 blocks reads" : " R9 blocks writes"}, inReady, 0);
    inWrite = onRead ? 1'b1 : 1'b0; #1;
    chk(inReady == 1'b1, {tag, onRead ? " R8 writes pass" : " R9 reads pass"}, inReady, 1);
    inWrite = onRead ? 1'b0 : 1'b1;
    inValid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
    end
    chk(txFrame == 1'b0, {tag, onRead ? " R8 held read not sent" : " R9 held write not sent"}, txFrame, 0);
    inValid = 1'b0;
    if (onRead) rdWaitAsync = 1'b0; else wrWaitAsync = 1'b0;
    @(negedge clk); #1;
    chk(inReady == 1'b0, {tag, " R7 release after one edge"}, inReady, 0);
    @(negedge clk); #1;
    chk(inReady == 1'b1, {tag, " R7 release after two edges"}, inReady, 1);
  endtask

  task automatic t_mid_wait;
    send_pkt(1'b0, 2'b01, 4'h7, 32'h3141_5926, 32'h0, 32'h2718_2818, 3, "midRd");
    inWrite = 1'b0; #1;
    chk(inReady == 1'b0, "R10 wait now holds reads", inReady, 0);
    rdWaitAsync = 1'b0; wrWaitAsync = 1'b0;
    repeat (3) @(negedge clk);
    send_pkt(1'b1, 2'b11, 4'hE, 32'h0BAD_CAFE, 32'h1357_9BDF, 32'h2468_ACE0, 5, "midW64");
    rdWaitAsync = 1'b0; wrWaitAsync = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_short_writes();
    t_long_packets();
    t_back_to_back();
    t_wait_gate(1'b1, "rdWait");
    t_wait_gate(1'b0, "wrWait");
    t_mid_wait();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule